// File: doc/BRIEF.md
# Express Channel Source VC Allocator

This block sits on one output port of a router that can start a multi-hop express virtual channel. The express VCs of that output are grouped into bins, one bin for each express length from 2 hops up to `MAX_LEN` hops. Every bin has its own pool of buffers at the downstream sink router. Shorter lengths get deeper pools. A head flit asks for an express VC of a given length. It is granted one in the same cycle only when that bin has a VC that is idle and whose credit state shows a buffer free at the sink. In every other case the request is pushed back to the normal VC path.

Credits are tracked per VC: the number of sink buffers each VC currently occupies. Each VC owns one buffer at the sink that no other VC may use. Any buffer beyond that is drawn from the bin's shared pool. A flit leaving on a VC takes one buffer. A credit coming back from the sink, possibly several hops away, gives one back. The tail flit frees the VC for a new packet, while its buffers stay counted until their credits return.

Top module: `evc_src_alloc`

## Requirements
- R1: After reset no express VC is busy and every bin reports its full depth as free credits.
- R2: The bin for express length L (2..MAX_LEN) is bin L-2. It holds VCs (L-2)*VCS_PER_BIN to (L-2)*VCS_PER_BIN+VCS_PER_BIN-1, and has depth BASE_DEPTH+(MAX_LEN-L)*DEPTH_STEP buffers.
- R3: A request of length L raises `allocExp` in the same cycle only if bin L-2 has a VC that is not busy and is ready. `allocVc` names that VC, and it shows busy from the next cycle.
- R4: Within a bin, the search for a VC starts at the VC after the one granted last in that bin, wrapping around. After reset it starts at the bin's first VC.
- R5: A request with a length outside 2..MAX_LEN, or with no eligible VC in its bin, raises `allocNormal` instead of `allocExp` and changes no state.
- R6: A flit sent on a VC that is busy and ready lowers its bin's free credits by one in the next cycle. A flit sent on a VC that is idle, not ready or out of range has no effect.
- R7: A flit sent with `sendTail` set on an accepted send leaves that VC not busy from the next cycle.
- R8: A returned credit raises the bin's free credits by one. A credit returned on a VC that holds no buffer is ignored, so free credits never exceed the bin depth and never go below zero.
- R9: A VC holding no buffer is always ready, because its own reserved buffer is free. A VC already holding buffers is ready only while the bin's shared pool (depth minus VCs_PER_BIN) has room, so no VC ever takes another VC's reserved buffer.
- R10: An accepted send and an accepted credit return in the same cycle leave the free credit count of a bin unchanged when both hit that bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Head flit requests an express VC |
| reqLen | input | LEN_W | Requested express length in hops |
| allocExp | output | 1 | Express VC granted this cycle |
| allocNormal | output | 1 | Request falls back to a normal VC |
| allocVc | output | VC_W | Index of the granted express VC |
| sendValid | input | 1 | A flit leaves on an express VC |
| sendVc | input | VC_W | VC of the departing flit |
| sendTail | input | 1 | Departing flit is a tail |
| retValid | input | 1 | Credit returned from a sink |
| retVc | input | VC_W | VC the credit belongs to |
| vcBusy | output | NUM_VC | VC currently owned by a packet |
| vcReady | output | NUM_VC | VC may send one more flit |
| binCredits | output | NUM_BINS*CNT_W | Free sink buffers per bin, bin 0 lowest |

## Verification
The bench builds the block with MAX_LEN=4, VCS_PER_BIN=2, BASE_DEPTH=3 and DEPTH_STEP=1. This gives three bins of depth 5, 4 and 3, whose shared pools hold 3, 2 and 1 buffers. These small pools let a few sends exhaust a shared pool. Pool exhaustion exercises the reserved-buffer rule, the credit-driven refusal of a grant, and the wrap of the round-robin pointer over two VCs. Six VCs and a three-bit VC field leave codes 6 and 7 out of range, so out-of-range sends and returns are exercised too.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int IDX_MAX_W = 8;

  typedef struct packed {
    logic                 allocEn;
    logic [IDX_MAX_W-1:0] allocIdx;
    logic                 sendEn;
    logic                 sendTail;
    logic [IDX_MAX_W-1:0] sendIdx;
    logic                 retEn;
    logic [IDX_MAX_W-1:0] retIdx;
  } evcStrobes_t;
endpackage

// File: rtl/evc_credit_dp.sv
module evc_credit_dp
  import evc_pkg::*;
#(
  parameter int NUM_BINS    = 3,
  parameter int NVC         = 2,
  parameter int BASE_DEPTH  = 3,
  parameter int DEPTH_STEP  = 1,
  parameter int NUM_VC      = 6,
  parameter int CNT_W       = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  evcStrobes_t               strb,
  output logic [NUM_VC-1:0]         vcBusy,
  output logic [NUM_VC-1:0]         vcReady,
  output logic [NUM_BINS*CNT_W-1:0] binCredits
);
  logic [CNT_W-1:0]  heldQ [NUM_VC];
  logic [NUM_VC-1:0] busyQ;
  logic [NUM_VC-1:0] sendHit;
  logic [NUM_VC-1:0] retHit;

  always_comb begin
    for (int v = 0; v < NUM_VC; v++) begin
      sendHit[v] = strb.sendEn && (strb.sendIdx == IDX_MAX_W'(v));
      retHit[v]  = strb.retEn && (strb.retIdx == IDX_MAX_W'(v)) && (heldQ[v] != '0);
    end
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    localparam int DEPTH  = BASE_DEPTH + (NUM_BINS - 1 - b) * DEPTH_STEP;
    localparam int SHARED = DEPTH - NVC;
    logic [CNT_W-1:0] usage;
    logic [CNT_W-1:0] total;
    logic [NVC-1:0]   readyB;
    logic             poolOpen;

    always_comb begin
      usage = '0;
      total = '0;
      for (int k = 0; k < NVC; k++) begin
        total = total + heldQ[b*NVC+k];
        if (heldQ[b*NVC+k] != '0) usage = usage + (heldQ[b*NVC+k] - CNT_W'(1));
      end
    end

    assign poolOpen = usage < CNT_W'(SHARED);

    always_comb begin
      for (int k = 0; k < NVC; k++) readyB[k] = (heldQ[b*NVC+k] == '0) || poolOpen;
    end

    assign vcReady[b*NVC +: NVC]        = readyB;
    assign binCredits[b*CNT_W +: CNT_W] = CNT_W'(DEPTH) - total;

    // R9: shared-pool use never reaches into the reserved buffers
    p_pool_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
      usage <= CNT_W'(SHARED));
    // R8: buffers held by the bin never exceed its depth
    p_credit_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
      total <= CNT_W'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= '0;
      for (int v = 0; v < NUM_VC; v++) heldQ[v] <= '0;
    end else begin
      for (int v = 0; v < NUM_VC; v++) begin
        if (strb.allocEn && strb.allocIdx == IDX_MAX_W'(v)) busyQ[v] <= 1'b1;
        else if (sendHit[v] && strb.sendTail)               busyQ[v] <= 1'b0;
        heldQ[v] <= heldQ[v] + CNT_W'(sendHit[v]) - CNT_W'(retHit[v]);
      end
    end
  end

  assign vcBusy = busyQ;

  // R10: send plus return on one VC keeps its buffer count
  for (genvar v = 0; v < NUM_VC; v++) begin : g_vcChk
    p_net_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
      (sendHit[v] && retHit[v]) |=> $stable(heldQ[v]));
  end
endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
#(
  parameter int MAX_LEN  = 4,
  parameter int NVC      = 2,
  parameter int NUM_BINS = 3,
  parameter int NUM_VC   = 6,
  parameter int LEN_W    = 3,
  parameter int VC_W     = 3,
  parameter int PTR_W    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              sendValid,
  input  logic [VC_W-1:0]   sendVc,
  input  logic              sendTail,
  input  logic              retValid,
  input  logic [VC_W-1:0]   retVc,
  input  logic [NUM_VC-1:0] vcBusy,
  input  logic [NUM_VC-1:0] vcReady,
  output logic              allocExp,
  output logic              allocNormal,
  output logic [VC_W-1:0]   allocVc,
  output evcStrobes_t       strb
);
  logic [PTR_W-1:0]    ptrQ    [NUM_BINS];
  logic [PTR_W-1:0]    binPick [NUM_BINS];
  logic [NUM_BINS-1:0] binHas;
  logic [NUM_BINS-1:0] binSel;
  logic                lenOk;
  logic                hit;
  logic                sendOk;
  int                  hitIdx;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_pick
    logic             found;
    logic [PTR_W-1:0] pick;
    always_comb begin
      int k;
      found = 1'b0;
      pick  = '0;
      for (int off = 0; off < NVC; off++) begin
        k = int'(ptrQ[b]) + off;
        if (k >= NVC) k = k - NVC;
        if (!found && !vcBusy[b*NVC+k] && vcReady[b*NVC+k]) begin
          found = 1'b1;
          pick  = PTR_W'(k);
        end
      end
    end
    assign binHas[b]  = found;
    assign binPick[b] = pick;
    assign binSel[b]  = lenOk && (reqLen == LEN_W'(b + 2));
  end

  assign lenOk = (reqLen >= LEN_W'(2)) && (reqLen <= LEN_W'(MAX_LEN));

  always_comb begin
    hit    = 1'b0;
    hitIdx = 0;
    for (int b = 0; b < NUM_BINS; b++) begin
      if (binSel[b] && binHas[b]) begin
        hit    = 1'b1;
        hitIdx = b * NVC + int'(binPick[b]);
      end
    end
  end

  assign allocExp    = reqValid && hit;
  assign allocNormal = reqValid && !hit;
  assign allocVc     = VC_W'(hitIdx);
  assign sendOk      = sendValid && (int'(sendVc) < NUM_VC) && vcBusy[sendVc] && vcReady[sendVc];

  always_comb begin
    strb          = '0;
    strb.allocEn  = allocExp;
    strb.allocIdx = IDX_MAX_W'(hitIdx);
    strb.sendEn   = sendOk;
    strb.sendTail = sendTail;
    strb.sendIdx  = IDX_MAX_W'(sendVc);
    strb.retEn    = retValid && (int'(retVc) < NUM_VC);
    strb.retIdx   = IDX_MAX_W'(retVc);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BINS; b++) ptrQ[b] <= '0;
    end else if (allocExp) begin
      for (int b = 0; b < NUM_BINS; b++) begin
        if (binSel[b]) ptrQ[b] <= (int'(binPick[b]) == NVC - 1) ? '0 : binPick[b] + PTR_W'(1);
      end
    end
  end

  // R5: a request takes exactly one path
  p_one_path_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (allocExp != allocNormal));
  // R3: only an idle, ready VC is granted
  p_grant_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    allocExp |-> (!vcBusy[allocVc] && vcReady[allocVc]));
  // R3: the granted VC is owned from the next cycle
  p_grant_owned_r3: assert property (@(posedge clk) disable iff (!rstN)
    allocExp |=> vcBusy[$past(allocVc)]);
  // R7: an accepted tail frees its VC
  p_tail_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sendOk && sendTail) |=> !vcBusy[$past(sendVc)]);
endmodule

// File: rtl/evc_src_alloc.sv
module evc_src_alloc
  import evc_pkg::*;
#(
  parameter  int MAX_LEN     = 4,
  parameter  int VCS_PER_BIN = 2,
  parameter  int BASE_DEPTH  = 3,
  parameter  int DEPTH_STEP  = 1,
  localparam int NUM_BINS    = MAX_LEN - 1,
  localparam int NUM_VC      = NUM_BINS * VCS_PER_BIN,
  localparam int LEN_W       = $clog2(MAX_LEN + 1),
  localparam int VC_W        = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int PTR_W       = (VCS_PER_BIN > 1) ? $clog2(VCS_PER_BIN) : 1,
  localparam int MAX_DEPTH   = BASE_DEPTH + (NUM_BINS - 1) * DEPTH_STEP,
  localparam int CNT_W       = $clog2(MAX_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [LEN_W-1:0]          reqLen,
  output logic                      allocExp,
  output logic                      allocNormal,
  output logic [VC_W-1:0]           allocVc,
  input  logic                      sendValid,
  input  logic [VC_W-1:0]           sendVc,
  input  logic                      sendTail,
  input  logic                      retValid,
  input  logic [VC_W-1:0]           retVc,
  output logic [NUM_VC-1:0]         vcBusy,
  output logic [NUM_VC-1:0]         vcReady,
  output logic [NUM_BINS*CNT_W-1:0] binCredits
);
  evcStrobes_t strb;

  evc_ctrl #(
    .MAX_LEN(MAX_LEN), .NVC(VCS_PER_BIN), .NUM_BINS(NUM_BINS), .NUM_VC(NUM_VC),
    .LEN_W(LEN_W), .VC_W(VC_W), .PTR_W(PTR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .sendValid(sendValid), .sendVc(sendVc), .sendTail(sendTail),
    .retValid(retValid), .retVc(retVc), .vcBusy(vcBusy), .vcReady(vcReady),
    .allocExp(allocExp), .allocNormal(allocNormal), .allocVc(allocVc), .strb(strb)
  );

  evc_credit_dp #(
    .NUM_BINS(NUM_BINS), .NVC(VCS_PER_BIN), .BASE_DEPTH(BASE_DEPTH),
    .DEPTH_STEP(DEPTH_STEP), .NUM_VC(NUM_VC), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .vcBusy(vcBusy), .vcReady(vcReady), .binCredits(binCredits)
  );
endmodule

// File: tb/sim_evc_src_alloc.sv
module sim_evc_src_alloc;
  localparam int NB = 3, NVC = 2, NV = 6, CW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, sendValid = 1'b0, sendTail = 1'b0, retValid = 1'b0;
  logic [2:0] reqLen = '0, sendVc = '0, retVc = '0;
  logic allocExp, allocNormal;
  logic [2:0] allocVc;
  logic [NV-1:0] vcBusy, vcReady;
  logic [NB*CW-1:0] binCredits;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  int busyM [NV];
  int heldM [NV];
  int ptrM  [NB];

  always #10 clk = ~clk;

  evc_src_alloc u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .allocExp(allocExp), .allocNormal(allocNormal), .allocVc(allocVc),
    .sendValid(sendValid), .sendVc(sendVc), .sendTail(sendTail),
    .retValid(retValid), .retVc(retVc), .vcBusy(vcBusy), .vcReady(vcReady),
    .binCredits(binCredits)
  );

  function automatic int dep(int b); return 3 + (NB - 1 - b); endfunction

  function automatic int usage(int b);
    int u = 0;
    for (int k = 0; k < NVC; k++) if (heldM[b*NVC+k] > 0) u += heldM[b*NVC+k] - 1;
    return u;
  endfunction

  function automatic bit readyM(int v);
    return heldM[v] == 0 || usage(v / NVC) < dep(v / NVC) - NVC;
  endfunction

  function automatic int creditsM(int b);
    int t = dep(b);
    for (int k = 0; k < NVC; k++) t -= heldM[b*NVC+k];
    return t;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // one cycle: drive, compare against the model, advance the model
  task automatic step(bit rv, int rl, bit sv, int svc, bit st, bit tv, int tvc);
    int expVc, eBusy, eReady, b;
    bit expExp, sOk, tOk;
    reqValid = rv; reqLen = 3'(rl); sendValid = sv; sendVc = 3'(svc);
    sendTail = st; retValid = tv; retVc = 3'(tvc);
    #1;
    expExp = 1'b0; expVc = 0;
    if (rv && rl >= 2 && rl <= 4) begin
      b = rl - 2;
      for (int off = 0; off < NVC; off++) begin
        int v = b * NVC + (ptrM[b] + off) % NVC;
        if (!expExp && busyM[v] == 0 && readyM(v)) begin expExp = 1'b1; expVc = v; end
      end
    end
    eBusy = 0; eReady = 0;
    for (int v = 0; v < NV; v++) begin
      eBusy  |= busyM[v] << v;
      eReady |= int'(readyM(v)) << v;
    end
    chk(allocExp == expExp, "R3/R5 allocExp", int'(allocExp), int'(expExp));
    chk(allocNormal == (rv && !expExp), "R5 allocNormal", int'(allocNormal), int'(rv && !expExp));
    if (expExp) chk(int'(allocVc) == expVc, "R4 allocVc", int'(allocVc), expVc);
    chk(int'(vcBusy) == eBusy, "R7 vcBusy", int'(vcBusy), eBusy);
    chk(int'(vcReady) == eReady, "R9 vcReady", int'(vcReady), eReady);
    for (int bb = 0; bb < NB; bb++) begin
      int c = int'(binCredits[bb*CW +: CW]);
      chk(c == creditsM(bb), "R6/R8/R10 binCredits", c, creditsM(bb));
      chk(c <= dep(bb), "R8 credit bound", c, dep(bb));
    end
    sOk = sv && svc < NV && busyM[svc] == 1 && readyM(svc);
    tOk = tv && tvc < NV && heldM[tvc] > 0;
    if (expExp) begin
      busyM[expVc] = 1;
      ptrM[expVc / NVC] = (expVc % NVC + 1) % NVC;
    end
    if (sOk) begin heldM[svc]++; if (st) busyM[svc] = 0; end
    if (tOk) heldM[tvc]--;
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    for (int v = 0; v < NV; v++) begin busyM[v] = 0; heldM[v] = 0; end
    for (int b = 0; b < NB; b++) ptrM[b] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 and R2: reset state and per-bin depths 5,4,3
    chk(vcBusy == '0, "R1 busy after reset", int'(vcBusy), 0);
    for (int b = 0; b < NB; b++)
      chk(int'(binCredits[b*CW +: CW]) == 5 - b, "R2 bin depth", int'(binCredits[b*CW +: CW]), 5 - b);
    @(negedge clk);

    // R3 R4: two grants in bin 0, then R5 fallback on full bin and bad lengths
    step(1, 2, 0, 0, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 5, 0, 0, 0, 0, 0);
    // R6: fill VC0 through the shared pool; extra sends are ignored
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, 0, 0);
    // R9: VC1 still ready on its reserved buffer
    chk(vcReady[1] == 1'b1 && vcReady[0] == 1'b0, "R9 reserved kept", int'(vcReady[1:0]), 2);
    step(0, 0, 1, 1, 0, 0, 0);
    chk(int'(binCredits[2:0]) == 0, "R6 bin0 empty", int'(binCredits[2:0]), 0);
    // R8: return on a VC holding nothing is ignored
    step(0, 0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 0, 1, 7);
    step(0, 0, 0, 0, 0, 1, 0);
    // R10: send and return together
    step(0, 0, 1, 0, 0, 1, 1);
    step(0, 0, 1, 1, 0, 1, 0);
    // R7: tails release, R6 send on idle VC ignored
    step(0, 0, 1, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 6, 0, 0, 0);
    // bin 2: credit-driven refusal with idle VC (R3)
    step(1, 4, 0, 0, 0, 0, 0);
    step(1, 4, 0, 0, 0, 0, 0);
    step(0, 0, 1, 4, 0, 0, 0);
    step(0, 0, 1, 4, 1, 0, 0);
    step(0, 0, 1, 5, 1, 0, 0);
    step(1, 4, 0, 0, 0, 0, 0);
    step(1, 4, 0, 0, 0, 0, 0);
    chk(vcReady[4] == 1'b0, "R3 VC4 not ready", int'(vcReady[4]), 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, 4 + i % 2);
    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 2) == 0, $urandom_range(0, 6), $urandom_range(0, 1),
           $urandom_range(0, 7), $urandom_range(0, 3) == 0,
           $urandom_range(0, 2) != 0, $urandom_range(0, 7));
    idle();
    finishRun();
  end
endmodule